// File: doc/BRIEF.md
# Floating-point operate instruction decoder

This block takes a 32-bit floating-point operate instruction word together with a valid strobe. It sorts the word into one of two operate groups, arithmetic/convert or compare, and looks up the 9-bit opcode within that group. For each of its three operand slots (first source, second source, destination) it reports a size class and says whether the operand is a packed floating-point value or a raw bit pattern. It also checks that double and quad register numbers are aligned, and that the destination field of a compare is zero, because a compare writes the condition code and not a register.

A correctly formed instruction comes out as a legal decode. A misaligned register or a nonzero compare destination comes out as a trap type of 6, with no decode. An unknown word is reported as not legal with a trap type of 0. The results are registered and appear one cycle after the strobe, together with a single-cycle done pulse, so that a downstream execution sequencer can pick its unpack/pack paths or raise an invalid-register exception.

Top module: `fpdec_top`

## Requirements
- R1: During and directly after reset, done_o and ok_o are 0, trap_o is 0, and all size and packed outputs are 0.
- R2: done_o is 1 in exactly the cycle after a cycle in which valid_i was 1, and 0 otherwise.
- R3: A word is in the arithmetic group when (insn & 0xC1F80000) == 0x81A00000 and in the compare group when the masked value is 0x81A80000. Any other word decodes as ok_o=0 and trap_o=0.
- R4: The opcode is insn bits 13:5 and is looked up only in the table of its own group. For example, 0x041 in the compare group, or 0x000 in the arithmetic group, gives ok_o=0 and trap_o=0.
- R5: Size classes use the codes 0=none, 1=single, 2=double, 3=quad. Examples: add 0x041/0x042/0x043 gives all three slots 1/2/3. 0x069 gives destination 2 and both sources 1. 0x06E gives destination 3 and both sources 2. Compares 0x051/0x055 have single sources and destination class 0. 0x053 has quad sources.
- R6: The packed flag is 1 for a floating-point operand and 0 for a raw one or an absent one. Move, negate and absolute value (0x001, 0x005, 0x009) have a raw source and a raw destination. Integer-to-float conversions (e.g. 0x0C8) have a raw source. Float-to-integer conversions (e.g. 0x0D2) have a raw destination.
- R7: A double operand whose register number (rs1 bits 18:14, rs2 bits 4:0, rd bits 29:25) has bit 0 set gives ok_o=0 and trap_o=6.
- R8: A quad operand whose register number has bit 0 or bit 1 set gives ok_o=0 and trap_o=6.
- R9: A compare with a nonzero rd field gives ok_o=0 and trap_o=6. A compare with rd=0 is legal.
- R10: Whenever ok_o=0, all size and packed outputs are 0.
- R11: Single operands have no alignment rule. The register field of an absent operand is ignored: fsqrtq 0x02B with rs1=3 is legal.
- R12: While valid_i is 0, ok_o, trap_o and the size and packed outputs keep their values whatever insn_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| done_o | output | 1 | Decode result present this cycle |
| ok_o | output | 1 | Recognised, with legal registers |
| trap_o | output | 3 | Trap type, 6 for an illegal register |
| rs1_sz_o | output | 2 | First source size class |
| rs2_sz_o | output | 2 | Second source size class |
| rd_sz_o | output | 2 | Destination size class |
| rs1_pk_o | output | 1 | First source is packed floating point |
| rs2_pk_o | output | 1 | Second source is packed floating point |
| rd_pk_o | output | 1 | Destination is packed floating point |

## Verification
The bench sends quad operands that are misaligned only in bit 1. A check that looks at bit 0 alone would pass these as legal. It sends compares with nonzero rd, which a decoder that treated the compare destination as a register would accept. It sends a valid arithmetic opcode under the compare-group pattern, which would decode wrongly if the two tables were merged. It also sends an absent rs1 with an odd field, where an over-eager check would trap. Mixed-width forms are covered: 0x069 and 0x06E, plus raw/packed conversions. A design that swapped slots or flags there would report the wrong classes. Idle cycles with a changing insn_i would expose outputs that are not held.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 9;
  localparam int REG_W  = 5;
  localparam int TRAP_W = 3;
  localparam int NSLOT  = 3;  // 0: rs1, 1: rs2, 2: rd
  localparam logic [TRAP_W-1:0] TRAP_BADREG = 3'd6;
  localparam logic [INSN_W-1:0] GRP_MASK  = 32'hC1F8_0000;
  localparam logic [INSN_W-1:0] GRP_ARITH = 32'h81A0_0000;
  localparam logic [INSN_W-1:0] GRP_CMP   = 32'h81A8_0000;

  typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_S = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} sz_e;

  typedef struct packed {
    logic hit;
    sz_e  rd;
    logic rd_pk;
    sz_e  rs2;
    logic rs2_pk;
    sz_e  rs1;
    logic rs1_pk;
  } optype_t;

  function automatic optype_t mk(sz_e rd, logic rdp, sz_e b, logic bp, sz_e a, logic ap);
    optype_t t;
    t.hit = 1'b1;
    t.rd = rd;  t.rd_pk = rdp;
    t.rs2 = b;  t.rs2_pk = bp;
    t.rs1 = a;  t.rs1_pk = ap;
    return t;
  endfunction

  function automatic optype_t arith_lookup(logic [OP_W-1:0] op);
    optype_t t;
    t = '0;
    case (op)
      9'h02b:                         t = mk(SZ_Q, 1, SZ_Q, 1, SZ_NONE, 0);
      9'h043, 9'h047, 9'h04b, 9'h04f: t = mk(SZ_Q, 1, SZ_Q, 1, SZ_Q, 1);
      9'h06e:                         t = mk(SZ_Q, 1, SZ_D, 1, SZ_D, 1);
      9'h0c7:                         t = mk(SZ_S, 1, SZ_Q, 1, SZ_NONE, 0);
      9'h0cb:                         t = mk(SZ_D, 1, SZ_Q, 1, SZ_NONE, 0);
      9'h0cc:                         t = mk(SZ_Q, 1, SZ_S, 0, SZ_NONE, 0);
      9'h0cd:                         t = mk(SZ_Q, 1, SZ_S, 1, SZ_NONE, 0);
      9'h0ce:                         t = mk(SZ_Q, 1, SZ_D, 1, SZ_NONE, 0);
      9'h0d3:                         t = mk(SZ_S, 0, SZ_Q, 1, SZ_NONE, 0);
      9'h029:                         t = mk(SZ_S, 1, SZ_S, 1, SZ_NONE, 0);
      9'h02a:                         t = mk(SZ_D, 1, SZ_D, 1, SZ_NONE, 0);
      9'h042, 9'h046, 9'h04a, 9'h04e: t = mk(SZ_D, 1, SZ_D, 1, SZ_D, 1);
      9'h041, 9'h045, 9'h049, 9'h04d: t = mk(SZ_S, 1, SZ_S, 1, SZ_S, 1);
      9'h069:                         t = mk(SZ_D, 1, SZ_S, 1, SZ_S, 1);
      9'h0c6:                         t = mk(SZ_S, 1, SZ_D, 1, SZ_NONE, 0);
      9'h0c9:                         t = mk(SZ_D, 1, SZ_S, 1, SZ_NONE, 0);
      9'h0d1:                         t = mk(SZ_S, 0, SZ_S, 1, SZ_NONE, 0);
      9'h0d2:                         t = mk(SZ_S, 0, SZ_D, 1, SZ_NONE, 0);
      9'h0c4:                         t = mk(SZ_S, 1, SZ_S, 0, SZ_NONE, 0);
      9'h0c8:                         t = mk(SZ_D, 1, SZ_S, 0, SZ_NONE, 0);
      9'h001, 9'h005, 9'h009:         t = mk(SZ_S, 0, SZ_S, 0, SZ_NONE, 0);
      default:                        t = '0;
    endcase
    return t;
  endfunction

  function automatic optype_t cmp_lookup(logic [OP_W-1:0] op);
    optype_t t;
    t = '0;
    case (op)
      9'h051, 9'h055: t = mk(SZ_NONE, 0, SZ_S, 1, SZ_S, 1);
      9'h052, 9'h056: t = mk(SZ_NONE, 0, SZ_D, 1, SZ_D, 1);
      9'h053, 9'h057: t = mk(SZ_NONE, 0, SZ_Q, 1, SZ_Q, 1);
      default:        t = '0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/fpdec_optab.sv
module fpdec_optab
  import fpdec_pkg::*;
#(
  parameter int GRP = 0  // 0: arithmetic/convert, 1: compare
) (
  input  logic [OP_W-1:0] op_i,
  output optype_t         typ_o
);
  if (GRP == 0) begin : g_arith
    assign typ_o = arith_lookup(op_i);
  end else begin : g_cmp
    assign typ_o = cmp_lookup(op_i);
  end
endmodule

// File: rtl/fpdec_regchk.sv
module fpdec_regchk
  import fpdec_pkg::*;
#(
  parameter bit ZERO_IF_NONE = 1'b0  // absent slot must carry register 0 (compare destination)
) (
  input  logic             en_i,
  input  sz_e              sz_i,
  input  logic [REG_W-1:0] idx_i,
  output logic             bad_o
);
  always_comb begin
    bad_o = 1'b0;
    if (en_i) begin
      case (sz_i)
        SZ_Q:    bad_o = |idx_i[1:0];
        SZ_D:    bad_o = idx_i[0];
        SZ_S:    bad_o = 1'b0;
        default: bad_o = ZERO_IF_NONE ? |idx_i : 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              done_o,
  output logic              ok_o,
  output logic [TRAP_W-1:0] trap_o,
  output logic [1:0]        rs1_sz_o,
  output logic [1:0]        rs2_sz_o,
  output logic [1:0]        rd_sz_o,
  output logic              rs1_pk_o,
  output logic              rs2_pk_o,
  output logic              rd_pk_o
);
  localparam int NGRP = 2;

  logic [INSN_W-1:0] masked;
  logic [NGRP-1:0]   grp_hit;
  optype_t           grp_typ [NGRP];
  optype_t           typ;
  logic [OP_W-1:0]   opc;
  logic [REG_W-1:0]  slot_idx [NSLOT];
  sz_e               slot_sz  [NSLOT];
  logic [NSLOT-1:0]  slot_bad;
  logic              bad_reg, legal;

  assign masked     = insn_i & GRP_MASK;
  assign grp_hit[0] = (masked == GRP_ARITH);
  assign grp_hit[1] = (masked == GRP_CMP);
  assign opc        = insn_i[13:5];

  for (genvar g = 0; g < NGRP; g++) begin : g_tab
    fpdec_optab #(.GRP(g)) u_tab (.op_i(opc), .typ_o(grp_typ[g]));
  end

  always_comb begin
    typ = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_hit[g]) typ = grp_typ[g];
  end

  assign slot_idx[0] = insn_i[18:14];
  assign slot_idx[1] = insn_i[4:0];
  assign slot_idx[2] = insn_i[29:25];
  assign slot_sz[0]  = typ.rs1;
  assign slot_sz[1]  = typ.rs2;
  assign slot_sz[2]  = typ.rd;

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    fpdec_regchk #(.ZERO_IF_NONE(k == NSLOT-1)) u_chk (
      .en_i (typ.hit),
      .sz_i (slot_sz[k]),
      .idx_i(slot_idx[k]),
      .bad_o(slot_bad[k])
    );
  end

  assign bad_reg = |slot_bad;
  assign legal   = typ.hit & ~bad_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      ok_o     <= 1'b0;
      trap_o   <= '0;
      rs1_sz_o <= '0;
      rs2_sz_o <= '0;
      rd_sz_o  <= '0;
      rs1_pk_o <= 1'b0;
      rs2_pk_o <= 1'b0;
      rd_pk_o  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        ok_o     <= legal;
        trap_o   <= bad_reg ? TRAP_BADREG : '0;
        rs1_sz_o <= legal ? typ.rs1 : SZ_NONE;
        rs2_sz_o <= legal ? typ.rs2 : SZ_NONE;
        rd_sz_o  <= legal ? typ.rd  : SZ_NONE;
        rs1_pk_o <= legal & typ.rs1_pk;
        rs2_pk_o <= legal & typ.rs2_pk;
        rd_pk_o  <= legal & typ.rd_pk;
      end
    end
  end

  a_r2_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  a_r7_trap_excludes_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o != '0) |-> !ok_o);
  a_r8_trap_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o == '0) || (trap_o == TRAP_BADREG));
  a_r10_clear_when_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_o |-> (rs1_sz_o == '0 && rs2_sz_o == '0 && rd_sz_o == '0 && !rs1_pk_o && !rs2_pk_o && !rd_pk_o));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ok_o) && $stable(trap_o) && $stable(rd_sz_o) && $stable(rs2_sz_o) && $stable(rs1_sz_o)));
  a_r6_absent_not_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && rs1_sz_o == '0) |-> !rs1_pk_o);
endmodule

// File: tb/fpdec_top_tb_top.sv
module fpdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic        done, ok, rs1_pk, rs2_pk, rd_pk;
  logic [2:0]  trap;
  logic [1:0]  rs1_sz, rs2_sz, rd_sz;
  int          n_chk = 0, n_fail = 0;
  bit          fin = 1'b0;

  always #2.5 clk = ~clk;

  fpdec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .done_o(done), .ok_o(ok), .trap_o(trap),
    .rs1_sz_o(rs1_sz), .rs2_sz_o(rs2_sz), .rd_sz_o(rd_sz),
    .rs1_pk_o(rs1_pk), .rs2_pk_o(rs2_pk), .rd_pk_o(rd_pk)
  );

  // {ok, trap, rs1_sz, rs2_sz, rd_sz, rs1_pk, rs2_pk, rd_pk}
  function automatic logic [12:0] pack(logic o, logic [2:0] t, logic [1:0] a, logic [1:0] b,
                                       logic [1:0] d, logic ap, logic bp, logic dp);
    return {o, t, a, b, d, ap, bp, dp};
  endfunction

  function automatic logic [31:0] mk(bit cmp, logic [8:0] op, logic [4:0] rd,
                                     logic [4:0] rs1, logic [4:0] rs2);
    return {2'b10, rd, cmp ? 6'b110101 : 6'b110100, rs1, op, rs2};
  endfunction

  task automatic chk(string req, logic [12:0] got, logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [12:0] outs();
    return pack(ok, trap, rs1_sz, rs2_sz, rd_sz, rs1_pk, rs2_pk, rd_pk);
  endfunction

  // drive one word, sample at the next falling edge (one register stage)
  task automatic dec(string req, logic [31:0] w, logic [12:0] exp);
    @(negedge clk);
    valid = 1'b1;
    insn  = w;
    @(negedge clk);
    valid = 1'b0;
    chk({req, " done"}, {12'd0, done}, 13'd1);
    chk(req, outs(), exp);
  endtask

  localparam logic [12:0] UNREC = 13'd0;
  localparam logic [12:0] BADRG = {1'b0, 3'd6, 9'd0};

  task automatic t_reset();
    chk("R1 reset done", {12'd0, done}, 13'd0);
    chk("R1 reset outs", outs(), 13'd0);
  endtask

  task automatic t_sizes();
    dec("R5 R11 adds", mk(0, 9'h041, 5'd3, 5'd5, 5'd7), pack(1, 0, 1, 1, 1, 1, 1, 1));
    dec("R5 addd",     mk(0, 9'h042, 5'd2, 5'd4, 5'd6), pack(1, 0, 2, 2, 2, 1, 1, 1));
    dec("R5 addq",     mk(0, 9'h043, 5'd4, 5'd8, 5'd12), pack(1, 0, 3, 3, 3, 1, 1, 1));
    dec("R5 smuld",    mk(0, 9'h069, 5'd2, 5'd1, 5'd3), pack(1, 0, 1, 1, 2, 1, 1, 1));
    dec("R5 dmulq",    mk(0, 9'h06e, 5'd4, 5'd2, 5'd6), pack(1, 0, 2, 2, 3, 1, 1, 1));
    dec("R5 R9 cmpes", mk(1, 9'h055, 5'd0, 5'd3, 5'd9), pack(1, 0, 1, 1, 0, 1, 1, 0));
    dec("R5 cmpq",     mk(1, 9'h053, 5'd0, 5'd4, 5'd8), pack(1, 0, 3, 3, 0, 1, 1, 0));
  endtask

  task automatic t_raw();
    dec("R6 movs", mk(0, 9'h001, 5'd1, 5'd31, 5'd3), pack(1, 0, 0, 1, 1, 0, 0, 0));
    dec("R6 negs", mk(0, 9'h005, 5'd2, 5'd0, 5'd1), pack(1, 0, 0, 1, 1, 0, 0, 0));
    dec("R6 itod", mk(0, 9'h0c8, 5'd2, 5'd0, 5'd5), pack(1, 0, 0, 1, 2, 0, 0, 1));
    dec("R6 dtoi", mk(0, 9'h0d2, 5'd1, 5'd0, 5'd2), pack(1, 0, 0, 2, 1, 0, 1, 0));
  endtask

  task automatic t_align();
    dec("R7 addd rs2 odd",  mk(0, 9'h042, 5'd2, 5'd4, 5'd7), BADRG);
    dec("R7 addd rd odd",   mk(0, 9'h042, 5'd3, 5'd4, 5'd6), BADRG);
    dec("R8 addq rs1 b1",   mk(0, 9'h043, 5'd4, 5'd2, 5'd8), BADRG);
    dec("R8 addq rd b0",    mk(0, 9'h043, 5'd1, 5'd4, 5'd8), BADRG);
    dec("R8 dmulq rd b1",   mk(0, 9'h06e, 5'd2, 5'd2, 5'd6), BADRG);
    dec("R9 cmps rd nz",    mk(1, 9'h051, 5'd1, 5'd0, 5'd0), BADRG);
    dec("R11 sqrtq rs1 ign", mk(0, 9'h02b, 5'd8, 5'd3, 5'd4), pack(1, 0, 0, 3, 3, 0, 1, 1));
  endtask

  task automatic t_unrec();
    dec("R4 op 0 arith",   mk(0, 9'h000, 5'd0, 5'd0, 5'd0), UNREC);
    dec("R4 adds in cmp",  mk(1, 9'h041, 5'd0, 5'd0, 5'd0), UNREC);
    dec("R3 no group",     32'h0000_0820, UNREC);
    dec("R3 bad top bits", mk(0, 9'h041, 5'd0, 5'd0, 5'd0) ^ 32'h4000_0000, UNREC);
  endtask

  task automatic t_hold();
    dec("R12 setup", mk(0, 9'h043, 5'd4, 5'd8, 5'd12), pack(1, 0, 3, 3, 3, 1, 1, 1));
    for (int i = 0; i < 3; i++) begin
      insn = mk(0, 9'h041, 5'd1, 5'd3, 5'd5) + i;
      @(negedge clk);
      chk("R2 idle done", {12'd0, done}, 13'd0);
      chk("R12 held", outs(), pack(1, 0, 3, 3, 3, 1, 1, 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_raw();
    t_align();
    t_unrec();
    t_hold();
    fin = 1'b1;
  end

  initial begin
    fork
      wait (fin);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule